// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic FIR Filter

This block is a direct-form FIR filter with no multipliers. Each accepted sample enters a tap delay line. The filter then spends one clock on each bit position of the stored words. In every such clock, the same bit of each tap operand forms an address into small tables. Each table holds, for every address, the sum of the coefficients whose address bit is set. The table outputs are added, weighted by the power of two of the current bit, and accumulated. On the last (sign) bit cycle the weighted sum is subtracted. The result is the exact full-precision dot product of the coefficients and the last `TAPS` samples.

Coefficients are fixed by a parameter, and the tables are built at elaboration. No table has more than four address bits. Larger filters are split into several tables whose outputs are summed. A symmetric variant adds each pair of mirrored taps with bit-serial adders before the tables. This halves the table inputs and adds one bit cycle for the carry. An optional register stage between the table sum and the accumulator shortens the critical path and adds one clock of latency.

Top module: `da_fir`

## Requirements
- R1: After reset, `resultValid` is 0, `resultOut` is 0 and every tap holds zero, so the first results depend only on the samples accepted since reset.
- R2: Each result equals the sum over k of c[k]·x[n-k], where x[n] is the newest accepted sample (8-bit two's complement) and c[k] is the signed `COEF_W`-bit field at bits [k·COEF_W +: COEF_W] of `COEFS`. The result is computed at full precision, with no rounding.
- R3: A result appears as a one-cycle `resultValid` pulse exactly `BITS + PIPE` clocks after the edge that accepted its sample. `BITS` is `DATA_W`, or `DATA_W + 1` in symmetric mode. Every accepted sample yields exactly one result.
- R4: `sampleValid` is accepted only while the block is idle or in the final bit cycle of a word. At any other time it is ignored and neither shifts the delay line nor starts a result.
- R5: With `sampleValid` held high, one sample is accepted and one result is produced every `BITS` clocks.
- R6: The sign bit is weighted negatively, so samples of -128 and 127 combined with coefficients of -128 and 127 give exact results.
- R7: A tap count that is not a multiple of four is split into tables of at most four taps each, and the result stays exact.
- R8: With `SYMMETRIC` = 1, the filter behaves as a `TAPS`-tap filter with c[k] = c[TAPS-1-k], taken from the first ceil(TAPS/2) fields of `COEFS`. A pre-added pair of -128 samples (-256) is handled exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleIn | input | DATA_W | Two's-complement input sample |
| sampleValid | input | 1 | Sample offer strobe |
| resultOut | output | OUT_W | Signed filter output, held until the next result |
| resultValid | output | 1 | One-cycle pulse marking a new result |

## Verification
The hardest case to reach is a `sampleValid` that arrives in the middle of a word. At the ports it looks the same as a legal offer, and it must leave no trace. The stimulus drives random junk samples with the strobe high during every mid-word cycle of some words. It then checks that every later result still matches a history that excludes the junk. Back-to-back offers in the final bit cycle, with strobe gaps of random length between them, cover the word boundary from both sides. Runs of -128 and 127 against extreme coefficients cover the sign cycle and the ninth pre-add bit.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;
  localparam int IDX_W = 5;
  localparam int GRP_MAX = 4;

  typedef struct packed {
    logic load;
    logic active;
    logic first;
    logic last;
    logic [IDX_W-1:0] bitIdx;
  } strobe_t;
endpackage

// File: rtl/da_fir_ctrl.sv
module da_fir_ctrl
  import da_fir_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sampleValid,
  output strobe_t strb
);
  logic busy;
  logic [IDX_W-1:0] cnt;
  logic lastBit;
  logic accept;

  assign lastBit = busy && (cnt == IDX_W'(BITS - 1));
  assign accept  = sampleValid && (!busy || lastBit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (lastBit) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    strb.load   = accept;
    strb.active = busy;
    strb.first  = busy && (cnt == '0);
    strb.last   = lastBit;
    strb.bitIdx = cnt;
  end

  // R5
  load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load |=> (strb.active && strb.first));

  // R4
  word_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.active && !strb.last) |=> (strb.active && strb.bitIdx == $past(strb.bitIdx) + 1'b1));

  // R4
  idle_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.last && !strb.load) |=> !strb.active);
endmodule

// File: rtl/da_fir_table.sv
module da_fir_table #(
  parameter int N_IN = 4,
  parameter int COEF_W = 8,
  parameter int OUT_W = 16,
  parameter logic [N_IN*COEF_W-1:0] COEFS = '0
) (
  input  logic [N_IN-1:0]         addr,
  output logic signed [OUT_W-1:0] sumOut
);
  localparam int ENTRIES = 2 ** N_IN;

  function automatic logic signed [OUT_W-1:0] entryVal(input int e);
    logic signed [OUT_W-1:0] s;
    s = '0;
    for (int j = 0; j < N_IN; j++) begin
      if (e[j]) s = s + OUT_W'(signed'(COEFS[j*COEF_W +: COEF_W]));
    end
    return s;
  endfunction

  logic signed [OUT_W-1:0] entries [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    assign entries[e] = entryVal(e);
  end

  assign sumOut = entries[addr];
endmodule

// File: rtl/da_fir_datapath.sv
module da_fir_datapath
  import da_fir_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TAPS = 8,
  parameter int COEF_W = 8,
  parameter bit SYMMETRIC = 1'b0,
  parameter bit PIPE = 1'b0,
  parameter int OUT_W = 21,
  parameter logic [TAPS*COEF_W-1:0] COEFS = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DATA_W-1:0]       sampleIn,
  input  strobe_t                 strb,
  output logic signed [OUT_W-1:0] resultOut,
  output logic                    resultValid
);
  localparam int NUM_OP  = SYMMETRIC ? (TAPS + 1) / 2 : TAPS;
  localparam int NUM_GRP = (NUM_OP + GRP_MAX - 1) / GRP_MAX;

  logic [DATA_W-1:0] taps [TAPS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS; k++) taps[k] <= '0;
    end else if (strb.load) begin
      taps[0] <= sampleIn;
      for (int k = 1; k < TAPS; k++) taps[k] <= taps[k-1];
    end
  end

  function automatic logic bitOf(input logic [DATA_W-1:0] w, input logic [IDX_W-1:0] i);
    logic r;
    r = w[DATA_W-1];
    for (int b = 0; b < DATA_W; b++) begin
      if (int'(i) == b) r = w[b];
    end
    return r;
  endfunction

  logic [NUM_OP-1:0] opBits;

  for (genvar j = 0; j < NUM_OP; j++) begin : g_op
    if (SYMMETRIC) begin : g_sym
      logic aBit, bBit, cIn, carryQ;
      assign aBit = bitOf(taps[j], strb.bitIdx);
      if (TAPS - 1 - j != j) begin : g_pair
        assign bBit = bitOf(taps[TAPS-1-j], strb.bitIdx);
      end else begin : g_mid
        assign bBit = 1'b0;
      end
      assign cIn = strb.first ? 1'b0 : carryQ;
      assign opBits[j] = aBit ^ bBit ^ cIn;
      always_ff @(posedge clk) begin
        if (!rst_n) carryQ <= 1'b0;
        else if (strb.active) carryQ <= (aBit & bBit) | (aBit & cIn) | (bBit & cIn);
      end
    end else begin : g_plain
      assign opBits[j] = bitOf(taps[j], strb.bitIdx);
    end
  end

  logic signed [OUT_W-1:0] grpSum [NUM_GRP];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam int BASE = g * GRP_MAX;
    localparam int N = (NUM_OP - BASE > GRP_MAX) ? GRP_MAX : NUM_OP - BASE;
    da_fir_table #(
      .N_IN  (N),
      .COEF_W(COEF_W),
      .OUT_W (OUT_W),
      .COEFS (COEFS[BASE*COEF_W +: N*COEF_W])
    ) u_tbl (
      .addr  (opBits[BASE +: N]),
      .sumOut(grpSum[g])
    );
  end

  logic signed [OUT_W-1:0] treeSum;
  always_comb begin
    treeSum = '0;
    for (int g = 0; g < NUM_GRP; g++) treeSum = treeSum + grpSum[g];
  end

  logic signed [OUT_W-1:0] accIn;
  strobe_t accStrb;

  if (PIPE) begin : g_pipe
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        accIn   <= '0;
        accStrb <= '0;
      end else begin
        accIn   <= treeSum;
        accStrb <= strb;
      end
    end
  end else begin : g_nopipe
    assign accIn   = treeSum;
    assign accStrb = strb;
  end

  logic signed [OUT_W-1:0] acc, weighted, accNext;
  assign weighted = accIn <<< accStrb.bitIdx;
  assign accNext  = (accStrb.first ? '0 : acc) + (accStrb.last ? -weighted : weighted);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc         <= '0;
      resultOut   <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= accStrb.active && accStrb.last;
      if (accStrb.active) acc <= accNext;
      if (accStrb.active && accStrb.last) resultOut <= accNext;
    end
  end

  // R3
  result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid |=> !resultValid);

  // R3
  result_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resultValid) |-> $past(accStrb.last));

  // R3
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !resultValid |-> $stable(resultOut));
endmodule

// File: rtl/da_fir.sv
module da_fir
  import da_fir_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TAPS = 8,
  parameter int COEF_W = 8,
  parameter bit SYMMETRIC = 1'b0,
  parameter bit PIPE = 1'b0,
  parameter logic [TAPS*COEF_W-1:0] COEFS =
    {8'hF0, 8'h22, 8'h7F, 8'h80, 8'h09, 8'hC3, 8'h11, 8'h05},
  localparam int OUT_W = COEF_W + DATA_W + int'(SYMMETRIC) + $clog2(TAPS) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DATA_W-1:0]       sampleIn,
  input  logic                    sampleValid,
  output logic signed [OUT_W-1:0] resultOut,
  output logic                    resultValid
);
  localparam int BITS = DATA_W + int'(SYMMETRIC);

  strobe_t strb;

  da_fir_ctrl #(.BITS(BITS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sampleValid(sampleValid),
    .strb       (strb)
  );

  da_fir_datapath #(
    .DATA_W   (DATA_W),
    .TAPS     (TAPS),
    .COEF_W   (COEF_W),
    .SYMMETRIC(SYMMETRIC),
    .PIPE     (PIPE),
    .OUT_W    (OUT_W),
    .COEFS    (COEFS)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .sampleIn   (sampleIn),
    .strb       (strb),
    .resultOut  (resultOut),
    .resultValid(resultValid)
  );
endmodule

// File: tb/da_fir_tb.sv
`timescale 1ns/1ps
module da_fir_tb;
  localparam int TAPS_A = 9;
  localparam int TAPS_B = 10;
  localparam int HALF_B = 5;
  localparam int LAT_A = 9;
  localparam int LAT_B = 9;
  localparam int BITS_A = 8;
  localparam int BITS_B = 9;
  localparam logic [TAPS_A*8-1:0] COEF_A =
    {8'h9C, 8'h00, 8'h01, 8'hB3, 8'h40, 8'hFD, 8'h05, 8'h80, 8'h7F};
  localparam logic [HALF_B*8-1:0] COEF_B_HALF =
    {8'h5A, 8'hF9, 8'h21, 8'h7F, 8'h80};
  localparam logic [TAPS_B*8-1:0] COEF_B = {40'h0, COEF_B_HALF};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] dataIn = '0;
  logic vA = 1'b0;
  logic vB = 1'b0;
  logic signed [20:0] outA;
  logic signed [21:0] outB;
  logic validA, validB;

  always #2.5 clk = ~clk;

  da_fir #(.TAPS(TAPS_A), .PIPE(1'b1), .COEFS(COEF_A)) u_dut (
    .clk(clk), .rst_n(rst_n), .sampleIn(dataIn), .sampleValid(vA),
    .resultOut(outA), .resultValid(validA));

  da_fir #(.TAPS(TAPS_B), .SYMMETRIC(1'b1), .COEFS(COEF_B)) u_sym (
    .clk(clk), .rst_n(rst_n), .sampleIn(dataIn), .sampleValid(vB),
    .resultOut(outB), .resultValid(validB));

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;
  string curReq = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  int histA [TAPS_A];
  int histB [TAPS_B];
  int expA [512];
  int cycA [512];
  int expB [512];
  int cycB [512];
  int headA = 0, tailA = 0, headB = 0, tailB = 0;

  function automatic int coefA(int k);
    return int'(signed'(COEF_A[k*8 +: 8]));
  endfunction

  function automatic int coefB(int k);
    int m;
    m = (k < TAPS_B - 1 - k) ? k : TAPS_B - 1 - k;
    return int'(signed'(COEF_B_HALF[m*8 +: 8]));
  endfunction

  task automatic check(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic push(int which, logic [7:0] x);
    int s;
    s = 0;
    if (which == 0) begin
      for (int k = TAPS_A - 1; k > 0; k--) histA[k] = histA[k-1];
      histA[0] = int'(signed'(x));
      for (int k = 0; k < TAPS_A; k++) s += coefA(k) * histA[k];
      expA[tailA] = s;
      cycA[tailA] = cyc + LAT_A;
      tailA++;
    end else begin
      for (int k = TAPS_B - 1; k > 0; k--) histB[k] = histB[k-1];
      histB[0] = int'(signed'(x));
      for (int k = 0; k < TAPS_B; k++) s += coefB(k) * histB[k];
      expB[tailB] = s;
      cycB[tailB] = cyc + LAT_B;
      tailB++;
    end
  endtask

  // one accepted sample, then junk (optional) during mid-word cycles, then extra idle
  task automatic send(int which, logic [7:0] x, int extra, bit junk);
    int bits;
    bits = (which == 0) ? BITS_A : BITS_B;
    @(negedge clk);
    dataIn = x;
    if (which == 0) vA = 1'b1; else vB = 1'b1;
    @(posedge clk);
    #1;
    push(which, x);
    for (int i = 1; i <= bits - 1 + extra; i++) begin
      @(negedge clk);
      dataIn = 8'($urandom);
      if (which == 0) vA = junk && (i <= bits - 1);
      else vB = junk && (i <= bits - 1);
      @(posedge clk);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (validA) begin
        if (headA < tailA) begin
          check(curReq, "dutA value", int'(outA), expA[headA]);
          check("R3", "dutA latency", cyc, cycA[headA]);
          headA++;
        end else check("R3", "dutA unexpected result", 1, 0);
      end else if (headA < tailA && cyc > cycA[headA]) begin
        check("R3", "dutA missing result", 0, 1);
        headA++;
      end
      if (validB) begin
        if (headB < tailB) begin
          check(curReq, "dutB value", int'(outB), expB[headB]);
          check("R3", "dutB latency", cyc, cycB[headB]);
          headB++;
        end else check("R3", "dutB unexpected result", 1, 0);
      end else if (headB < tailB && cyc > cycB[headB]) begin
        check("R3", "dutB missing result", 0, 1);
        headB++;
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < TAPS_A; k++) histA[k] = 0;
    for (int k = 0; k < TAPS_B; k++) histB[k] = 0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1", "dutA valid in reset", int'(validA), 0);
    check("R1", "dutA output in reset", int'(outA), 0);
    check("R1", "dutB valid in reset", int'(validB), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "dutA output after reset", int'(outA), 0);
    check("R1", "dutB output after reset", int'(outB), 0);

    // R7: impulse walks through all 9 taps (tables of 4,4,1)
    curReq = "R7";
    send(0, 8'd1, 2, 1'b0);
    for (int i = 0; i < TAPS_A; i++) send(0, 8'd0, 1, 1'b0);

    // R2: random samples with random gaps
    curReq = "R2";
    for (int i = 0; i < 20; i++) send(0, 8'($urandom), int'($urandom % 4), 1'b0);

    // R6: sign-bit extremes
    curReq = "R6";
    for (int i = 0; i < 10; i++) send(0, 8'h80, 1, 1'b0);
    for (int i = 0; i < 10; i++) send(0, 8'h7F, 0, 1'b0);
    for (int i = 0; i < 10; i++) send(0, (i % 2 == 0) ? 8'h80 : 8'h7F, 0, 1'b0);

    // R4: mid-word offers carry junk and must leave no trace
    curReq = "R4";
    for (int i = 0; i < 15; i++) send(0, 8'($urandom), int'($urandom % 3), 1'b1);

    // R5: back-to-back accepts every 8 clocks
    curReq = "R5";
    for (int i = 0; i < 40; i++) send(0, 8'($urandom), 0, 1'b0);
    @(negedge clk); vA = 1'b0;
    repeat (20) @(negedge clk);

    // R8: symmetric variant, 10 taps, pre-add of -128 pairs
    curReq = "R8";
    for (int i = 0; i < 12; i++) send(1, 8'h80, 0, 1'b0);
    for (int i = 0; i < 12; i++) send(1, 8'h7F, 1, 1'b0);
    for (int i = 0; i < 30; i++) send(1, 8'($urandom), int'($urandom % 3), (i % 3) == 0);
    @(negedge clk); vB = 1'b0;
    repeat (30) @(negedge clk);

    check("R3", "dutA results drained", headA, tailA);
    check("R3", "dutB results drained", headB, tailB);
    finishRun();
  end
endmodule